// File: doc/BRIEF.md
# Card host transmit FIFO start controller

This block holds outgoing write data for a memory-card host and decides in which cycle the card-side engine may begin sending it. The fill point that triggers a start is chosen from the configured block length. Short blocks wait until all of their words are buffered. Long blocks start early, once a fixed fraction of the FIFO holds data. A mode bit can override this so that a single buffered word is enough. The block also records overflow, which is a push into a full FIFO, and underflow, which is a card-side pop from an empty FIFO while a transfer runs. Either flag clears in one of two software-selectable ways.

A small configuration word holds four mode bits. Writes to it are refused while the write-protect input is high. The fill point is counted in words pushed since the current block began. A block ends when the number of pushed words equals the block length, and the next push then starts a new block. A new-command strobe also starts a new block.

Top module: `card_txq_ctrl`

## Requirements
- R1: After reset the fill level is 0, the start pulse is low, both error flags are low and the configuration word reads 0.
- R2: While `cfg_wp` is low, a `cfg_wr` strobe stores four configuration bits, readable one cycle later. The bits are: any-word start at bit 0, read-clears-error at bit 4, high-speed at bit 8, last-block sync at bit 12. Every other bit reads 0, so writing all ones reads back 0x00001111.
- R3: While `cfg_wp` is high, a `cfg_wr` strobe leaves the configuration word unchanged.
- R4: The FIFO is 16 words of 32 bits and returns words in push order, with `pop_data` showing the oldest word. A push while 16 words are held is dropped, the level stays at 16, and `ovf_err` rises on the next cycle.
- R5: With bit 0 set, `start_xfer` pulses in the cycle after the first push of a block.
- R6: With bit 0 clear and a block length of 12 or more, `start_xfer` pulses after the 8th push of the block.
- R7: With bit 0 clear and a block length from 8 to 11, `start_xfer` pulses after the 4th push of the block.
- R8: With bit 0 clear and a block length from 1 to 7, `start_xfer` pulses after the push that completes the block.
- R9: `start_xfer` is a one-cycle pulse issued once per block. It re-arms after the number of pushed words reaches the block length. A `new_cmd` strobe restarts the count, so pushes made before the strobe do not count toward the fill point.
- R10: A pop with the FIFO empty raises `unf_err` only if a start has been issued since the last `new_cmd`.
- R11: With bit 4 clear, `status_rd` leaves a set error flag unchanged, and `new_cmd` clears it.
- R12: With bit 4 set, `status_rd` clears a set error flag, and `new_cmd` leaves it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_wp | input | 1 | Write-protect enable; blocks configuration writes when high |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rdata | output | 32 | Configuration read data |
| blk_len | input | 12 | Block length in words |
| push | input | 1 | Host-side write strobe |
| push_data | input | 32 | Word to store |
| pop | input | 1 | Card-side read strobe |
| pop_data | output | 32 | Oldest stored word |
| new_cmd | input | 1 | New read/write command strobe |
| status_rd | input | 1 | Status read strobe |
| start_xfer | output | 1 | One-cycle pulse: write transfer may begin |
| level | output | 5 | Number of stored words |
| ovf_err | output | 1 | Overflow flag |
| unf_err | output | 1 | Underflow flag |
| flow_err | output | 1 | OR of the two error flags |

## Verification
A wrong push count inside a block shows up as `start_xfer` arriving at the wrong push. This is visible one cycle after the push that should have triggered it, or as a second pulse within the same block. A wrong threshold branch moves the pulse between pushes 1, 4, 8 and the block end, and the table of block lengths on both sides of each boundary is there to catch it. A corrupt level or pointer appears as a wrong `level`, a word out of order on `pop_data`, or a missed `ovf_err` one cycle after the 17th push. A wrong clear path shows as an error flag that survives, or drops, one cycle after a status read or a new command.

// File: rtl/card_txq_pkg.sv
package card_txq_pkg;

   typedef struct packed {
      logic last_sync;
      logic hs_mode;
      logic rd_clr_err;
      logic any_word;
   } txq_cfg_t;

   localparam int unsigned POS_ANY   = 0;
   localparam int unsigned POS_RDCLR = 4;
   localparam int unsigned POS_HS    = 8;
   localparam int unsigned POS_LSYNC = 12;

endpackage

// File: rtl/txq_cfg_reg.sv
module txq_cfg_reg
   import card_txq_pkg::*;
#(
   parameter int unsigned REG_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic             wp_en,
   input  logic [REG_W-1:0] wdata,
   output txq_cfg_t         cfg_o,
   output logic [REG_W-1:0] rdata
);

   generate
      if (REG_W <= POS_LSYNC) begin : g_bad_width
         $error("txq_cfg_reg: REG_W too small for field layout");
      end
   endgenerate

   txq_cfg_t cfg_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cfg_q <= '0;
      end else if (wr_en && !wp_en) begin
         cfg_q.any_word   <= wdata[POS_ANY];
         cfg_q.rd_clr_err <= wdata[POS_RDCLR];
         cfg_q.hs_mode    <= wdata[POS_HS];
         cfg_q.last_sync  <= wdata[POS_LSYNC];
      end
   end

   always_comb begin
      rdata            = '0;
      rdata[POS_ANY]   = cfg_q.any_word;
      rdata[POS_RDCLR] = cfg_q.rd_clr_err;
      rdata[POS_HS]    = cfg_q.hs_mode;
      rdata[POS_LSYNC] = cfg_q.last_sync;
   end

   assign cfg_o = cfg_q;

   assert_wp_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wp_en) |=> $stable(cfg_q));

   assert_cfg_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !wp_en) |=> (cfg_q.any_word == $past(wdata[POS_ANY])));

endmodule

// File: rtl/txq_fifo.sv
module txq_fifo #(
   parameter int unsigned DW    = 32,
   parameter int unsigned DEPTH = 16,
   localparam int unsigned AW   = $clog2(DEPTH),
   localparam int unsigned LW   = AW + 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          push,
   input  logic [DW-1:0] wdata,
   input  logic          pop,
   output logic [DW-1:0] rdata,
   output logic [LW-1:0] level,
   output logic          full,
   output logic          empty,
   output logic          push_ok,
   output logic          pop_ok
);

   generate
      if (DEPTH < 4 || (1 << AW) != DEPTH) begin : g_bad_depth
         $error("txq_fifo: DEPTH must be a power of two, at least 4");
      end
   endgenerate

   logic [DW-1:0] mem [DEPTH];
   logic [AW-1:0] wr_ptr, rd_ptr;
   logic [LW-1:0] level_q;

   assign full    = (level_q == LW'(DEPTH));
   assign empty   = (level_q == '0);
   assign push_ok = push && !full;
   assign pop_ok  = pop && !empty;

   generate
      for (genvar e = 0; e < DEPTH; e++) begin : g_slot
         localparam logic [AW-1:0] SLOT = AW'(e);
         always_ff @(posedge clk) begin
            if (push_ok && wr_ptr == SLOT) mem[e] <= wdata;
         end
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wr_ptr  <= '0;
         rd_ptr  <= '0;
         level_q <= '0;
      end else begin
         if (push_ok) wr_ptr <= wr_ptr + AW'(1);
         if (pop_ok)  rd_ptr <= rd_ptr + AW'(1);
         case ({push_ok, pop_ok})
            2'b10:   level_q <= level_q + LW'(1);
            2'b01:   level_q <= level_q - LW'(1);
            default: level_q <= level_q;
         endcase
      end
   end

   assign rdata = mem[rd_ptr];
   assign level = level_q;

   assert_level_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
      level_q <= LW'(DEPTH));

   assert_full_drop_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (push && full && !pop) |=> (level_q == LW'(DEPTH)));

   assert_level_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (push_ok && !pop_ok) |=> (level_q == $past(level_q) + LW'(1)));

endmodule

// File: rtl/txq_start_ctrl.sv
module txq_start_ctrl #(
   parameter int unsigned DEPTH = 16,
   parameter int unsigned LEN_W = 12
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             any_word,
   input  logic [LEN_W-1:0] blk_len,
   input  logic             push_ok,
   input  logic             new_cmd,
   output logic             start_o,
   output logic             active_o
);

   localparam int unsigned MARK_3Q = (DEPTH * 3) / 4;
   localparam int unsigned MARK_HF = DEPTH / 2;
   localparam int unsigned MARK_1Q = DEPTH / 4;

   generate
      if (LEN_W <= $clog2(DEPTH)) begin : g_bad_len
         $error("txq_start_ctrl: LEN_W must exceed the FIFO address width");
      end
   endgenerate

   logic [LEN_W-1:0] thr, blk_cnt, cnt_nx;
   logic             hit, blk_end, start_q, active_q;

   always_comb begin
      if (any_word)                       thr = LEN_W'(1);
      else if (blk_len >= LEN_W'(MARK_3Q)) thr = LEN_W'(MARK_HF);
      else if (blk_len >= LEN_W'(MARK_HF)) thr = LEN_W'(MARK_1Q);
      else                                 thr = blk_len;
   end

   assign cnt_nx  = blk_cnt + LEN_W'(1);
   assign hit     = push_ok && (blk_len != '0) && (cnt_nx == thr);
   assign blk_end = (cnt_nx == blk_len);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         blk_cnt  <= '0;
         start_q  <= 1'b0;
         active_q <= 1'b0;
      end else if (new_cmd) begin
         blk_cnt  <= '0;
         start_q  <= 1'b0;
         active_q <= 1'b0;
      end else begin
         start_q <= hit;
         if (hit) active_q <= 1'b1;
         if (push_ok) blk_cnt <= blk_end ? '0 : cnt_nx;
      end
   end

   assign start_o  = start_q;
   assign active_o = active_q;

   assert_start_after_push_R9: assert property (@(posedge clk) disable iff (!rst_n)
      start_q |-> $past(push_ok));

   assert_rearm_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (push_ok && !new_cmd && blk_end) |=> (blk_cnt == '0));

   assert_start_activates_R10: assert property (@(posedge clk) disable iff (!rst_n)
      start_q |-> active_q);

endmodule

// File: rtl/txq_flow_err.sv
module txq_flow_err (
   input  logic clk,
   input  logic rst_n,
   input  logic push,
   input  logic full,
   input  logic pop,
   input  logic empty,
   input  logic active,
   input  logic new_cmd,
   input  logic status_rd,
   input  logic rd_clr_mode,
   output logic ovf_o,
   output logic unf_o
);

   logic ovf_set, unf_set, clr, ovf_q, unf_q;

   assign ovf_set = push && full;
   assign unf_set = pop && empty && active;
   assign clr     = rd_clr_mode ? status_rd : new_cmd;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ovf_q <= 1'b0;
         unf_q <= 1'b0;
      end else begin
         ovf_q <= ovf_set || (ovf_q && !clr);
         unf_q <= unf_set || (unf_q && !clr);
      end
   end

   assign ovf_o = ovf_q;
   assign unf_o = unf_q;

   assert_ovf_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (push && full) |=> ovf_q);

   assert_hold_cmd_mode_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (ovf_q && !rd_clr_mode && !new_cmd) |=> ovf_q);

   assert_hold_rd_mode_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (unf_q && rd_clr_mode && !status_rd) |=> unf_q);

   assert_no_idle_unf_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (!unf_q && !(pop && empty && active)) |=> !unf_q);

endmodule

// File: rtl/card_txq_ctrl.sv
module card_txq_ctrl
   import card_txq_pkg::*;
#(
   parameter int unsigned DW    = 32,
   parameter int unsigned DEPTH = 16,
   parameter int unsigned LEN_W = 12,
   localparam int unsigned LW   = $clog2(DEPTH) + 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cfg_wr,
   input  logic             cfg_wp,
   input  logic [31:0]      cfg_wdata,
   output logic [31:0]      cfg_rdata,
   input  logic [LEN_W-1:0] blk_len,
   input  logic             push,
   input  logic [DW-1:0]    push_data,
   input  logic             pop,
   output logic [DW-1:0]    pop_data,
   input  logic             new_cmd,
   input  logic             status_rd,
   output logic             start_xfer,
   output logic [LW-1:0]    level,
   output logic             ovf_err,
   output logic             unf_err,
   output logic             flow_err
);

   txq_cfg_t cfg;
   logic     full, empty, push_ok, pop_ok, active;

   txq_cfg_reg #(.REG_W(32)) u_cfg (
      .clk   (clk),
      .rst_n (rst_n),
      .wr_en (cfg_wr),
      .wp_en (cfg_wp),
      .wdata (cfg_wdata),
      .cfg_o (cfg),
      .rdata (cfg_rdata)
   );

   txq_fifo #(.DW(DW), .DEPTH(DEPTH)) u_fifo (
      .clk     (clk),
      .rst_n   (rst_n),
      .push    (push),
      .wdata   (push_data),
      .pop     (pop),
      .rdata   (pop_data),
      .level   (level),
      .full    (full),
      .empty   (empty),
      .push_ok (push_ok),
      .pop_ok  (pop_ok)
   );

   txq_start_ctrl #(.DEPTH(DEPTH), .LEN_W(LEN_W)) u_start (
      .clk      (clk),
      .rst_n    (rst_n),
      .any_word (cfg.any_word),
      .blk_len  (blk_len),
      .push_ok  (push_ok),
      .new_cmd  (new_cmd),
      .start_o  (start_xfer),
      .active_o (active)
   );

   txq_flow_err u_err (
      .clk         (clk),
      .rst_n       (rst_n),
      .push        (push),
      .full        (full),
      .pop         (pop),
      .empty       (empty),
      .active      (active),
      .new_cmd     (new_cmd),
      .status_rd   (status_rd),
      .rd_clr_mode (cfg.rd_clr_err),
      .ovf_o       (ovf_err),
      .unf_o       (unf_err)
   );

   assign flow_err = ovf_err || unf_err;

   assert_reset_quiet_R1: assert property (@(posedge clk)
      !rst_n |=> (level == '0 && !start_xfer && !flow_err));

endmodule

// File: tb/card_txq_ctrl_test.sv
module card_txq_ctrl_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_wr = 1'b0, cfg_wp = 1'b0;
   logic [31:0] cfg_wdata = '0;
   logic [31:0] cfg_rdata;
   logic [11:0] blk_len = '0;
   logic        push = 1'b0, pop = 1'b0, new_cmd = 1'b0, status_rd = 1'b0;
   logic [31:0] push_data = '0;
   logic [31:0] pop_data;
   logic        start_xfer, ovf_err, unf_err, flow_err;
   logic [4:0]  level;

   int n_chk = 0;
   int n_bad = 0;

   always #5 clk = ~clk;

   card_txq_ctrl uut (
      .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_wp(cfg_wp),
      .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .blk_len(blk_len),
      .push(push), .push_data(push_data), .pop(pop), .pop_data(pop_data),
      .new_cmd(new_cmd), .status_rd(status_rd), .start_xfer(start_xfer),
      .level(level), .ovf_err(ovf_err), .unf_err(unf_err), .flow_err(flow_err)
   );

   // {any_word(4), block length(6), push index of the start pulse(6)}
   localparam logic [15:0] VEC [0:9] = '{
      {4'h1, 6'd16, 6'd1}, {4'h1, 6'd3,  6'd1},
      {4'h0, 6'd16, 6'd8}, {4'h0, 6'd12, 6'd8},
      {4'h0, 6'd11, 6'd4}, {4'h0, 6'd8,  6'd4},
      {4'h0, 6'd7,  6'd7}, {4'h0, 6'd5,  6'd5},
      {4'h0, 6'd1,  6'd1}, {4'h0, 6'd13, 6'd8}
   };

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
      end
   endtask

   // entered at a falling edge; drives for one rising edge; returns at the next falling edge
   task automatic step(input logic p, input logic [31:0] d, input logic po,
                       input logic nc, input logic sr);
      push = p; push_data = d; pop = po; new_cmd = nc; status_rd = sr;
      @(negedge clk);
      push = 1'b0; pop = 1'b0; new_cmd = 1'b0; status_rd = 1'b0;
   endtask

   task automatic wcfg(input logic [31:0] d, input logic wp);
      cfg_wr = 1'b1; cfg_wdata = d; cfg_wp = wp;
      @(negedge clk);
      cfg_wr = 1'b0; cfg_wp = 1'b0;
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
   endtask

   initial begin
      #1_000_000;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      @(negedge clk);
      do_reset();

      // R1 reset state
      check("R1 level", 32'(level), 0);
      check("R1 start", 32'(start_xfer), 0);
      check("R1 flags", 32'({ovf_err, unf_err, flow_err}), 0);
      check("R1 cfg", cfg_rdata, 0);

      // R2 / R3 configuration access
      wcfg(32'hFFFF_FFFF, 1'b0);
      check("R2 readback", cfg_rdata, 32'h0000_1111);
      wcfg(32'h0000_0000, 1'b1);
      check("R3 protected", cfg_rdata, 32'h0000_1111);
      wcfg(32'h0000_0100, 1'b0);
      check("R2 single bit", cfg_rdata, 32'h0000_0100);

      // R5..R8 start point table
      for (int v = 0; v < 10; v++) begin
         logic       mode;
         int         len, expi, first, pulses;
         string      tag;
         mode = VEC[v][12];
         len  = int'(VEC[v][11:6]);
         expi = int'(VEC[v][5:0]);
         tag  = mode ? "R5" : (len >= 12 ? "R6" : (len >= 8 ? "R7" : "R8"));
         do_reset();
         wcfg({31'd0, mode}, 1'b0);
         blk_len = 12'(len);
         first = 0; pulses = 0;
         for (int i = 1; i <= len; i++) begin
            step(1'b1, 32'(i), 1'b0, 1'b0, 1'b0);
            if (start_xfer) begin
               pulses++;
               if (first == 0) first = i;
            end
         end
         check({tag, " start index"}, 32'(first), 32'(expi));
         check({tag, " one pulse"}, 32'(pulses), 1);
      end

      // R9 re-arm per block: any-word mode, block of 2, four pushes
      do_reset();
      wcfg(32'h1, 1'b0);
      blk_len = 12'd2;
      begin
         logic [3:0] seen;
         seen = '0;
         for (int i = 0; i < 4; i++) begin
            step(1'b1, 32'(i), 1'b0, 1'b0, 1'b0);
            seen[i] = start_xfer;
         end
         check("R9 rearm pattern", 32'(seen), 32'h5);
      end

      // R9 new command restarts the count (block of 4, start after whole block)
      do_reset();
      blk_len = 12'd4;
      step(1'b1, 32'h1, 1'b0, 1'b0, 1'b0);
      step(1'b1, 32'h2, 1'b0, 1'b0, 1'b0);
      step(1'b0, 32'h0, 1'b0, 1'b1, 1'b0);
      begin
         int early;
         early = 0;
         for (int i = 0; i < 3; i++) begin
            step(1'b1, 32'(i), 1'b0, 1'b0, 1'b0);
            if (start_xfer) early++;
         end
         check("R9 no start before restart count", 32'(early), 0);
         step(1'b1, 32'h9, 1'b0, 1'b0, 1'b0);
         check("R9 start after restarted block", 32'(start_xfer), 1);
      end

      // R4 overflow and ordering, R11 command-cleared mode
      do_reset();
      blk_len = 12'd16;
      for (int i = 0; i < 16; i++) step(1'b1, 32'hA000_0000 + 32'(i), 1'b0, 1'b0, 1'b0);
      check("R4 full level", 32'(level), 16);
      check("R4 no overflow yet", 32'(ovf_err), 0);
      step(1'b1, 32'hDEAD_BEEF, 1'b0, 1'b0, 1'b0);
      check("R4 level held", 32'(level), 16);
      check("R4 overflow flag", 32'(ovf_err), 1);
      check("R4 flow_err", 32'(flow_err), 1);
      check("R4 head word", pop_data, 32'hA000_0000);
      step(1'b0, 32'h0, 1'b0, 1'b0, 1'b1);
      check("R11 status read ignored", 32'(ovf_err), 1);
      step(1'b0, 32'h0, 1'b0, 1'b1, 1'b0);
      check("R11 new command clears", 32'(ovf_err), 0);

      // R12 read-cleared mode
      wcfg(32'h10, 1'b0);
      step(1'b1, 32'h1234, 1'b0, 1'b0, 1'b0);
      check("R12 overflow again", 32'(ovf_err), 1);
      step(1'b0, 32'h0, 1'b0, 1'b1, 1'b0);
      check("R12 new command ignored", 32'(ovf_err), 1);
      step(1'b0, 32'h0, 1'b0, 1'b0, 1'b1);
      check("R12 status read clears", 32'(ovf_err), 0);

      step(1'b0, 32'h0, 1'b1, 1'b0, 1'b0);
      check("R4 order after pop", pop_data, 32'hA000_0001);
      check("R4 level after pop", 32'(level), 15);

      // R10 underflow only while active
      do_reset();
      step(1'b0, 32'h0, 1'b1, 1'b0, 1'b0);
      check("R10 idle pop no flag", 32'(unf_err), 0);
      wcfg(32'h1, 1'b0);
      blk_len = 12'd4;
      step(1'b1, 32'h55, 1'b0, 1'b0, 1'b0);
      check("R10 start issued", 32'(start_xfer), 1);
      step(1'b0, 32'h0, 1'b1, 1'b0, 1'b0);
      check("R10 drained", 32'(level), 0);
      check("R10 no flag yet", 32'(unf_err), 0);
      step(1'b0, 32'h0, 1'b1, 1'b0, 1'b0);
      check("R10 underflow flag", 32'(unf_err), 1);
      step(1'b0, 32'h0, 1'b0, 1'b0, 1'b1);
      check("R11 underflow kept on status read", 32'(unf_err), 1);
      step(1'b0, 32'h0, 1'b0, 1'b1, 1'b0);
      check("R11 underflow cleared by command", 32'(unf_err), 0);
      step(1'b0, 32'h0, 1'b1, 1'b0, 1'b0);
      check("R10 inactive after command", 32'(unf_err), 0);

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

endmodule